// File: doc/BRIEF.md
# Saturating Fixed-Point PID Controller Core

This core computes one step of a discrete-time proportional-integral-derivative control law for each sample it receives. A sample is a signed setpoint, a signed feedback value and three signed gains. All of them use a 16-bit two's-complement format with 8 fractional bits, so one unit is 0x0100. The core forms the control error, multiplies it by the gains, keeps a running integral and the error from the previous sample, and produces one control word for each sample. Every intermediate result is clamped to the 16-bit signed range. Values that grow too large saturate and never wrap.

The work is split into four registered stages: error capture, gain multiplication, term accumulation and output summation. Each stage is kept short so the core runs comfortably at 50 MHz. A sample is offered by raising `in_valid` for one cycle. The matching result appears on `ctrl_out` together with a one-cycle `out_valid` pulse. A new sample may be offered on every cycle. Cycles without `in_valid` leave the controller state untouched.

Top module: `pid_core`

## Requirements
- R1: The error is setpoint minus feedback, computed wider than 16 bits and clamped to the range 0x8000..0x7FFF (for example setpoint 0x7FFF with feedback 0x8000 gives an error of 0x7FFF).
- R2: The proportional term is the full-width product of Kp and the error, shifted right arithmetically by 8 (rounding toward minus infinity) and clamped to 16 bits.
- R3: On each sample the stored integral becomes clamp(integral + clamp((Ki × error) >>> 8)). It holds at 0x7FFF while the increments stay non-negative and at 0x8000 while they stay negative, and it never wraps.
- R4: The derivative term is clamp((Kd × clamp(error − previous error)) >>> 8). The previous error is the clamped error of the preceding valid sample, and 0 after reset.
- R5: `ctrl_out` equals clamp(P + I + D), where I is the integral after the current sample's update and the sum is formed wider than 16 bits.
- R6: A sample taken at a rising edge with `in_valid` high produces exactly one `out_valid` pulse, visible just after the third following rising edge. Results come out in the order their samples went in, and `ctrl_out` holds its value while `out_valid` is low.
- R7: Cycles with `in_valid` low change neither the integral nor the previous error, whatever the other inputs carry.
- R8: Synchronous active-high `rst` clears the integral, the previous error, every pipeline register, `out_valid` and `ctrl_out` (to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the sample inputs for this cycle |
| setpoint | input | 16 | Target value, signed Q8.8 |
| feedback | input | 16 | Measured value, signed Q8.8 |
| gain_p | input | 16 | Proportional gain, signed Q8.8 |
| gain_i | input | 16 | Integral gain, signed Q8.8 |
| gain_d | input | 16 | Derivative gain, signed Q8.8 |
| out_valid | output | 1 | One-cycle pulse marking a new control word |
| ctrl_out | output | 16 | Saturated control output, signed Q8.8 |

## Verification
The hardest condition to reach from the ports is an integrator pinned at either rail while later samples keep pushing it further out and then pull it back. Random gains rarely hold it there long enough to expose a wrap. Directed runs with a near-maximum integral gain and a large error of fixed sign drive the integral into each rail and hold it there. The sign of the error is then flipped so the integral must leave the rail smoothly. Gaps filled with garbage inputs are placed between samples, and a reset is applied mid-run, to show that only qualified samples move the stored state.

// File: rtl/pid_pkg.sv
package pid_pkg;

    localparam int W        = 16;
    localparam int WX       = 2 * W + 1;
    localparam int FRAC_DEF = 8;
    localparam int NTERM    = 3;

    typedef logic signed [W-1:0]  q_t;
    typedef logic signed [WX-1:0] wide_t;

    localparam wide_t Q_MAX = wide_t'((2 ** (W - 1)) - 1);
    localparam wide_t Q_MIN = wide_t'(-(2 ** (W - 1)));

    typedef enum int {
        TERM_P = 0,
        TERM_I = 1,
        TERM_D = 2
    } term_e;

    // operands captured by the first stage
    typedef struct packed {
        q_t err;
        q_t diff;
        q_t kp;
        q_t ki;
        q_t kd;
    } front_t;

    function automatic wide_t widen(input q_t x);
        return wide_t'(x);
    endfunction

    function automatic q_t clamp_q(input wide_t v);
        if (v > Q_MAX)
            return Q_MAX[W-1:0];
        else if (v < Q_MIN)
            return Q_MIN[W-1:0];
        else
            return v[W-1:0];
    endfunction

    function automatic q_t qmul(input q_t a, input q_t b, input int frac);
        wide_t prod;
        prod = widen(a) * widen(b);
        return clamp_q(prod >>> frac);
    endfunction

endpackage

// File: rtl/pid_front.sv
module pid_front
    import pid_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  q_t     setpoint,
    input  q_t     feedback,
    input  q_t     kp,
    input  q_t     ki,
    input  q_t     kd,
    output front_t front_q,
    output logic   valid_q,
    output q_t     prev_err
);

    q_t err_now;
    q_t diff_now;

    always_comb begin
        err_now  = clamp_q(widen(setpoint) - widen(feedback));
        diff_now = clamp_q(widen(err_now) - widen(prev_err));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            front_q  <= '0;
            valid_q  <= 1'b0;
            prev_err <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                front_q.err  <= err_now;
                front_q.diff <= diff_now;
                front_q.kp   <= kp;
                front_q.ki   <= ki;
                front_q.kd   <= kd;
                prev_err     <= err_now;
            end
        end
    end

endmodule

// File: rtl/pid_qmul.sv
module pid_qmul
    import pid_pkg::*;
#(
    parameter int FRAC = FRAC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  q_t   a,
    input  q_t   b,
    output q_t   y
);

    always_ff @(posedge clk) begin
        if (rst)
            y <= '0;
        else if (en)
            y <= qmul(a, b, FRAC);
    end

endmodule

// File: rtl/pid_accum.sv
module pid_accum
    import pid_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic valid_in,
    input  q_t   p_term,
    input  q_t   i_incr,
    input  q_t   d_term,
    output q_t   integ,
    output logic out_valid,
    output q_t   ctrl_out
);

    q_t   p_hold;
    q_t   d_hold;
    logic valid_c;

    // stage C: integrator update, P and D aligned with it
    always_ff @(posedge clk) begin
        if (rst) begin
            integ   <= '0;
            p_hold  <= '0;
            d_hold  <= '0;
            valid_c <= 1'b0;
        end else begin
            valid_c <= valid_in;
            if (valid_in) begin
                integ  <= clamp_q(widen(integ) + widen(i_incr));
                p_hold <= p_term;
                d_hold <= d_term;
            end
        end
    end

    // stage D: three-term sum, clamped
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            ctrl_out  <= '0;
        end else begin
            out_valid <= valid_c;
            if (valid_c)
                ctrl_out <= clamp_q(widen(p_hold) + widen(integ) + widen(d_hold));
        end
    end

endmodule

// File: rtl/pid_core.sv
module pid_core
    import pid_pkg::*;
#(
    parameter int FRAC = FRAC_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [15:0]  setpoint,
    input  logic signed [15:0]  feedback,
    input  logic signed [15:0]  gain_p,
    input  logic signed [15:0]  gain_i,
    input  logic signed [15:0]  gain_d,
    output logic                out_valid,
    output logic signed [15:0]  ctrl_out
);

    front_t front_q;
    logic   valid_a;
    logic   valid_b;
    q_t     prev_err_w;
    q_t     integ_w;
    q_t     gain_v [NTERM];
    q_t     opnd_v [NTERM];
    q_t     term_v [NTERM];

    pid_front u_front (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .setpoint (setpoint),
        .feedback (feedback),
        .kp       (gain_p),
        .ki       (gain_i),
        .kd       (gain_d),
        .front_q  (front_q),
        .valid_q  (valid_a),
        .prev_err (prev_err_w)
    );

    assign gain_v[TERM_P] = front_q.kp;
    assign gain_v[TERM_I] = front_q.ki;
    assign gain_v[TERM_D] = front_q.kd;
    assign opnd_v[TERM_P] = front_q.err;
    assign opnd_v[TERM_I] = front_q.err;
    assign opnd_v[TERM_D] = front_q.diff;

    // stage B: one registered multiplier per term
    for (genvar t = 0; t < NTERM; t++) begin : g_mul
        pid_qmul #(.FRAC(FRAC)) u_mul (
            .clk (clk),
            .rst (rst),
            .en  (valid_a),
            .a   (gain_v[t]),
            .b   (opnd_v[t]),
            .y   (term_v[t])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            valid_b <= 1'b0;
        else
            valid_b <= valid_a;
    end

    pid_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_b),
        .p_term    (term_v[TERM_P]),
        .i_incr    (term_v[TERM_I]),
        .d_term    (term_v[TERM_D]),
        .integ     (integ_w),
        .out_valid (out_valid),
        .ctrl_out  (ctrl_out)
    );

endmodule

// File: rtl/pid_core_chk.sv
module pid_core_chk
    import pid_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic valid_b,
    input logic out_valid,
    input q_t   ctrl_out,
    input q_t   prev_err,
    input q_t   integ,
    input q_t   i_incr
);

    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 4));

    p_hold_out_r6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(ctrl_out));

    p_prev_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(prev_err));

    p_integ_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_b |=> $stable(integ));

    p_integ_top_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_b && integ == 16'sh7FFF && !i_incr[15]) |=> integ == 16'sh7FFF);

    p_integ_bot_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_b && integ == 16'sh8000 && i_incr[15]) |=> integ == 16'sh8000);

    p_reset_r8: assert property (@(posedge clk)
        rst |=> (!out_valid && integ == '0 && prev_err == '0 && ctrl_out == '0));

endmodule

bind pid_core pid_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .valid_b   (valid_b),
    .out_valid (out_valid),
    .ctrl_out  (ctrl_out),
    .prev_err  (prev_err_w),
    .integ     (integ_w),
    .i_incr    (term_v[TERM_I])
);

// File: tb/pid_core_test.sv
module pid_core_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] setpoint = '0, feedback = '0;
    logic signed [15:0] gain_p = '0, gain_i = '0, gain_d = '0;
    logic out_valid;
    logic signed [15:0] ctrl_out;

    pid_core uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .setpoint(setpoint), .feedback(feedback),
        .gain_p(gain_p), .gain_i(gain_i), .gain_d(gain_d),
        .out_valid(out_valid), .ctrl_out(ctrl_out)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // expected results in issue order
    logic signed [15:0] exp_v [0:1023];
    int    exp_c [0:1023];
    string exp_tag [0:1023];
    int head = 0;
    int tail = 0;

    // reference model state
    int m_int = 0;
    int m_prev = 0;

    function automatic int sat(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int mq(input int a, input int b);
        longint p;
        p = longint'(a) * longint'(b);
        return sat(p >>> 8);
    endfunction

    task automatic fail(input string req, input int act, input int expv);
        errors++;
        $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    endtask

    task automatic send(input int sp, input int fb, input int kp, input int ki,
                        input int kd, input string tag);
        int e, d, p, k, dd, o;
        setpoint = 16'(sp); feedback = 16'(fb);
        gain_p = 16'(kp); gain_i = 16'(ki); gain_d = 16'(kd);
        in_valid = 1'b1;
        e  = sat(longint'(int'(setpoint)) - longint'(int'(feedback)));
        d  = sat(longint'(e) - longint'(m_prev));
        m_prev = e;
        p  = mq(int'(gain_p), e);
        k  = mq(int'(gain_i), e);
        dd = mq(int'(gain_d), d);
        m_int = sat(longint'(m_int) + longint'(k));
        o  = sat(longint'(p) + longint'(m_int) + longint'(dd));
        exp_v[tail] = 16'(o);
        exp_c[tail] = cyc + 4;
        exp_tag[tail] = tag;
        tail++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // idle cycles carrying garbage on the unqualified inputs
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            setpoint = 16'($urandom); feedback = 16'($urandom);
            gain_p = 16'($urandom); gain_i = 16'($urandom); gain_d = 16'($urandom);
            @(negedge clk);
        end
    endtask

    // output monitor: R6 timing and per-sample value
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (head < tail && exp_c[head] == cyc) begin
                checks++;
                if (out_valid !== 1'b1) fail("R6 missing out_valid", int'(out_valid), 1);
                checks++;
                if (ctrl_out !== exp_v[head])
                    fail(exp_tag[head], int'(ctrl_out), int'(exp_v[head]));
                head++;
            end else if (out_valid !== 1'b0) begin
                checks++;
                fail("R6 unexpected out_valid", int'(out_valid), 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || ctrl_out !== 16'sd0)
            fail("R8 reset state", int'(ctrl_out), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: error clamping at both rails
        send(16'h7FFF, 16'h8000, 16'h0100, 0, 0, "R1 error clamp high");
        send(16'h8000, 16'h7FFF, 16'h0100, 0, 0, "R1 error clamp low");
        // R2: fractional products, floor rounding
        send(16'h0300, 16'h0100, 16'h0180, 0, 0, "R2 P 2.0*1.5");
        send(16'h0001, 16'h0000, 16'hFF80, 0, 0, "R2 P floor negative");
        send(16'h2000, 16'h0000, 16'h7FFF, 0, 0, "R2 P clamp");
        idle(6);

        // R3: integrator windup to top, held, then to bottom
        for (int i = 0; i < 6; i++)
            send(16'h4000, 16'h0000, 0, 16'h7FFF, 0, "R3 integ to top");
        for (int i = 0; i < 10; i++)
            send(16'hC000, 16'h0000, 0, 16'h7FFF, 0, "R3 integ to bottom");
        send(16'h0100, 16'h0000, 0, 16'h0100, 0, "R3 leave bottom");
        idle(6);

        // R4 and R7: derivative uses previous valid error across gaps
        send(16'h0200, 16'h0000, 0, 0, 16'h0100, "R4 D first");
        idle(3);
        send(16'h0500, 16'h0000, 0, 0, 16'h0100, "R7 D after gap");
        idle(5);
        send(16'h0100, 16'h0000, 0, 16'h0080, 16'h0200, "R7 I and D after gap");
        send(16'h8000, 16'h7FFF, 0, 0, 16'h0100, "R4 diff clamp");

        // R5: sum of three terms clamped
        send(16'h7000, 16'h0000, 16'h7FFF, 16'h7FFF, 16'h7FFF, "R5 sum clamp high");
        send(16'h9000, 16'h0000, 16'h7FFF, 16'h7FFF, 16'h0100, "R5 sum clamp low");
        idle(8);

        // R8: reset in mid run clears integral and previous error
        send(16'h0400, 16'h0000, 0, 16'h0100, 16'h0100, "R8 before reset");
        idle(8);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || ctrl_out !== 16'sd0)
            fail("R8 mid-run reset", int'(ctrl_out), 0);
        m_int = 0; m_prev = 0; head = 0; tail = 0;
        rst = 1'b0;
        @(negedge clk);
        send(16'h0100, 16'h0000, 0, 16'h0100, 16'h0100, "R8 state cleared");
        idle(6);

        // random samples with random gaps
        for (int i = 0; i < 400; i++) begin
            int kp, ki, kd;
            kp = int'(16'($urandom));
            ki = int'(16'($urandom));
            kd = int'(16'($urandom));
            if ($urandom_range(0, 1) == 1) begin
                kp = kp >>> 6; ki = ki >>> 8; kd = kd >>> 6;
            end
            send(int'(16'($urandom)), int'(16'($urandom)), kp, ki, kd, "R5 random");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
            if (tail > 1000) begin
                idle(6);
                head = 0; tail = 0;
            end
        end
        idle(8);
        checks++;
        if (head != tail) fail("R6 outputs outstanding", tail - head, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule